// File: doc/BRIEF.md
# Multiplexed Segment LCD Drive Sequencer

This block sets the timing of a multiplexed segment LCD and picks the drive level for every glass pin. A programmable divider cuts the input clock into common phases, so the refresh rate can be set anywhere in the 10 Hz to 150 Hz range. A phase counter steps through the active commons. A polarity bit keeps the drive on the glass free of DC. For each pin the block puts out a 3-bit index into six analog levels: code 0 is ground and codes 1 to 5 are the bias ladder taps. A separate analog stage turns the index into a voltage.

Each pin is set up as a common (backplane) or a segment (frontplane). A common pin also carries the phase index it is active in. Segment pixel data comes in on a wide next-frame bus and is held in a shadow register. The shadow register loads only at a frame boundary. At that same edge a one-cycle request goes out so an external transfer engine can present the following frame. Two waveform types are supported, plus a global image inversion. Type A flips polarity every phase. Type B is the low-power type and flips polarity once per frame.

A three-state controller sequences the block. IDLE parks every pin at ground. PRIME loads the first frame and raises the request. RUN drives the glass. Transitions: IDLE to PRIME when `en` is high; PRIME to RUN when `en` stays high, PRIME to IDLE otherwise; RUN to IDLE when `en` drops. Reset leads to IDLE.

Top module: `lcd_mux_seq`

## Requirements
- R1: A synchronous reset drives every pin code to 0 (ground) and `frame_req` low, and clears the phase counter and polarity.
- R2: While the controller is in IDLE (`en` low), all pin codes are 0. The first clock edge with `en` high enters PRIME for one cycle. In PRIME, pin codes are 0, `frame_req` is 1, and `seg_next` is captured. The next edge enters RUN at phase 0 with positive polarity (pol=0).
- R3: In RUN, each common phase lasts exactly `div_lim`+1 clock cycles.
- R4: The phase counts 0,1,...,`com_num` and then wraps to 0. With `com_num`=0 the display runs static, with a single phase.
- R5: When `wave_b`=0 (Type A), polarity toggles at the end of every phase.
- R6: When `wave_b`=1 (Type B), polarity toggles only when the phase wraps from `com_num` to 0.
- R7: Let T be the top level. A common pin whose index equals the current phase drives T when pol=0 and 0 when pol=1. Any other common pin drives 1 when pol=0 and T-1 when pol=1.
- R8: A segment pin whose pixel is on drives 0 when pol=0 and T when pol=1. An off segment drives T-1 when pol=0 and 1 when pol=1. The pixel for pin p in phase k is bit p*MAX_COM+k of the shadow register.
- R9: `bias_sel` sets T. The encoding is 0 for static (T=1), 1 for 1/2 (T=2), 2 for 1/3 (T=3), 3 for 1/4 (T=4) and 4 for 1/5 (T=5).
- R10: `invert`=1 complements every segment pixel before the level is chosen.
- R11: In RUN, `frame_req` is high for exactly the last cycle of the last phase of a frame. The shadow register loads on the edge that ends that cycle.
- R12: A change on `seg_next` in the middle of a frame leaves the pin codes of the current frame unchanged. The new data appears in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable |
| div_lim | input | DIV_W | Phase length minus one, in clock cycles |
| com_num | input | PH_W | Number of active commons minus one |
| bias_sel | input | 3 | Bias ratio select |
| wave_b | input | 1 | 0 = Type A waveform, 1 = Type B |
| invert | input | 1 | Negative image |
| pin_is_com | input | NPINS | 1 = pin is a common |
| pin_com_sel | input | NPINS*PH_W | Phase index of each common pin |
| seg_next | input | NPINS*MAX_COM | Next frame pixel data |
| frame_req | output | 1 | Request for the next frame |
| pin_lvl | output | NPINS*3 | Per-pin drive level code |

## Verification
Two effects are hard to reach from the ports: the Type B polarity flip, which happens only after a whole frame, and the moment a frame's data actually takes effect. The bench restarts the sequencer for every table vector and then advances it by a chosen number of phase ticks. This puts the pins in any phase/polarity pair under each waveform type and bias. For the double-buffer behaviour, the bench changes the next-frame bus one cycle into a frame. It then checks that the old pixels stay on the pins until the boundary request has passed.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRIME = 2'd1,
        ST_RUN   = 2'd2
    } seq_state_t;

    localparam int LVL_W = 3;

    function automatic logic [LVL_W-1:0] top_level(input logic [2:0] sel);
        logic [LVL_W-1:0] t;
        unique case (sel)
            3'd0:    t = 3'd1;
            3'd1:    t = 3'd2;
            3'd2:    t = 3'd3;
            3'd3:    t = 3'd4;
            default: t = 3'd5;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/lcd_tick_div.sv
module lcd_tick_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [DIV_W-1:0] lim,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (cnt >= lim)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = !clr && (cnt >= lim);
endmodule

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq
    import lcd_seq_pkg::*;
#(
    parameter int PH_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            tick,
    input  logic [PH_W-1:0] com_num,
    input  logic            wave_b,
    output logic            running,
    output logic            load,
    output logic [PH_W-1:0] phase,
    output logic            pol
);
    seq_state_t state, state_nx;
    logic       wrap;

    assign wrap = tick && (phase >= com_num);

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (en) state_nx = ST_PRIME;
            ST_PRIME: state_nx = en ? ST_RUN : ST_IDLE;
            ST_RUN:   if (!en) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        running = 1'b0;
        load    = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_PRIME: load = 1'b1;
            ST_RUN: begin
                running = 1'b1;
                load    = wrap;
            end
            default: ;
        endcase
    end

    // phase and polarity counters
    always_ff @(posedge clk) begin
        if (rst || state != ST_RUN) begin
            phase <= '0;
            pol   <= 1'b0;
        end else if (tick) begin
            phase <= wrap ? '0 : phase + 1'b1;
            if (!wave_b || wrap)
                pol <= ~pol;
        end
    end
endmodule

// File: rtl/lcd_pin_drv.sv
module lcd_pin_drv
    import lcd_seq_pkg::*;
#(
    parameter int MAX_COM = 16,
    parameter int PH_W    = 4
) (
    input  logic               drive,
    input  logic               is_com,
    input  logic [PH_W-1:0]    com_idx,
    input  logic [PH_W-1:0]    phase,
    input  logic               pol,
    input  logic               invert,
    input  logic [LVL_W-1:0]   top,
    input  logic [MAX_COM-1:0] pix,
    output logic [LVL_W-1:0]   code
);
    logic on;

    always_comb begin
        on   = pix[phase] ^ invert;
        code = '0;
        if (drive) begin
            if (is_com) begin
                if (com_idx == phase)
                    code = pol ? '0 : top;
                else
                    code = pol ? top - 1'b1 : 3'd1;
            end else begin
                if (on)
                    code = pol ? top : '0;
                else
                    code = pol ? 3'd1 : top - 1'b1;
            end
        end
    end
endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq
    import lcd_seq_pkg::*;
#(
    parameter int NPINS   = 8,
    parameter int MAX_COM = 16,
    parameter int DIV_W   = 16,
    localparam int PH_W   = $clog2(MAX_COM),
    localparam int SEG_W  = NPINS * MAX_COM
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic [DIV_W-1:0]       div_lim,
    input  logic [PH_W-1:0]        com_num,
    input  logic [2:0]             bias_sel,
    input  logic                   wave_b,
    input  logic                   invert,
    input  logic [NPINS-1:0]       pin_is_com,
    input  logic [NPINS*PH_W-1:0]  pin_com_sel,
    input  logic [SEG_W-1:0]       seg_next,
    output logic                   frame_req,
    output logic [NPINS*LVL_W-1:0] pin_lvl
);
    logic             tick, running, load, pol;
    logic [PH_W-1:0]  phase;
    logic [SEG_W-1:0] shadow;
    logic [LVL_W-1:0] top;

    assign top       = top_level(bias_sel);
    assign frame_req = load;

    lcd_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk (clk),
        .rst (rst),
        .clr (!running),
        .lim (div_lim),
        .tick(tick)
    );

    lcd_phase_seq #(.PH_W(PH_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .tick   (tick),
        .com_num(com_num),
        .wave_b (wave_b),
        .running(running),
        .load   (load),
        .phase  (phase),
        .pol    (pol)
    );

    always_ff @(posedge clk) begin
        if (rst)
            shadow <= '0;
        else if (load)
            shadow <= seg_next;
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        lcd_pin_drv #(.MAX_COM(MAX_COM), .PH_W(PH_W)) u_drv (
            .drive  (running),
            .is_com (pin_is_com[p]),
            .com_idx(pin_com_sel[p*PH_W +: PH_W]),
            .phase  (phase),
            .pol    (pol),
            .invert (invert),
            .top    (top),
            .pix    (shadow[p*MAX_COM +: MAX_COM]),
            .code   (pin_lvl[p*LVL_W +: LVL_W])
        );
    end
endmodule

// File: rtl/lcd_mux_seq_chk.sv
module lcd_mux_seq_chk #(
    parameter int NPINS   = 8,
    parameter int MAX_COM = 16,
    parameter int DIV_W   = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     en,
    input logic [DIV_W-1:0]         div_lim,
    input logic                     frame_req,
    input logic [NPINS*MAX_COM-1:0] shadow,
    input logic [NPINS*3-1:0]       pin_lvl
);
    a_r1_reset_ground: assert property (@(posedge clk)
        rst |=> (pin_lvl == '0) && !frame_req);

    a_r2_idle_ground: assert property (@(posedge clk) disable iff (rst)
        !en |=> (pin_lvl == '0));

    a_r11_req_single: assert property (@(posedge clk) disable iff (rst)
        (frame_req && div_lim != '0) |=> !frame_req);

    a_r12_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_req |=> $stable(shadow));

    always_ff @(posedge clk) begin
        if (!rst) begin
            for (int p = 0; p < NPINS; p++)
                a_r7_code_range: assert (pin_lvl[p*3 +: 3] <= 3'd5);
        end
    end
endmodule

bind lcd_mux_seq lcd_mux_seq_chk #(
    .NPINS  (NPINS),
    .MAX_COM(MAX_COM),
    .DIV_W  (DIV_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .div_lim  (div_lim),
    .frame_req(frame_req),
    .shadow   (shadow),
    .pin_lvl  (pin_lvl)
);

// File: tb/tb_lcd_mux_seq.sv
module tb_lcd_mux_seq;
    localparam int NP = 4;
    localparam int MC = 16;
    localparam int DW = 16;
    localparam int PW = 4;
    localparam int LIM = 3;

    typedef struct packed {
        logic [3:0]  com_n;
        logic [2:0]  bias;
        logic        wb;
        logic        inv;
        logic [3:0]  seg;   // {p3ph1,p3ph0,p2ph1,p2ph0}
        logic [2:0]  ticks;
        logic [11:0] exp;   // {p3,p2,p1,p0}
    } vec_t;

    localparam vec_t VEC [9] = '{
        '{4'd1, 3'd2, 1'b0, 1'b0, 4'b1001, 3'd0, {3'd2, 3'd0, 3'd1, 3'd3}}, // R7 R8 R9 1/3 A
        '{4'd1, 3'd2, 1'b0, 1'b0, 4'b1001, 3'd1, {3'd3, 3'd1, 3'd0, 3'd2}}, // R5 A pol flips
        '{4'd1, 3'd2, 1'b1, 1'b0, 4'b1001, 3'd1, {3'd0, 3'd2, 3'd3, 3'd1}}, // R6 B no flip
        '{4'd1, 3'd2, 1'b1, 1'b0, 4'b1001, 3'd2, {3'd1, 3'd3, 3'd2, 3'd0}}, // R6 B flip at wrap
        '{4'd1, 3'd4, 1'b0, 1'b1, 4'b1001, 3'd0, {3'd0, 3'd4, 3'd1, 3'd5}}, // R10 invert 1/5
        '{4'd1, 3'd1, 1'b0, 1'b0, 4'b1001, 3'd1, {3'd2, 3'd1, 3'd0, 3'd1}}, // R9 1/2
        '{4'd1, 3'd3, 1'b0, 1'b0, 4'b1001, 3'd3, {3'd4, 3'd1, 3'd0, 3'd3}}, // R4 1/4 wrap
        '{4'd0, 3'd0, 1'b0, 1'b0, 4'b1001, 3'd0, {3'd0, 3'd0, 3'd1, 3'd1}}, // R4 static
        '{4'd0, 3'd0, 1'b0, 1'b0, 4'b1001, 3'd1, {3'd1, 3'd1, 3'd0, 3'd0}}  // R4 static pol
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en = 1'b0;
    logic [DW-1:0]     div_lim = DW'(LIM);
    logic [PW-1:0]     com_num = '0;
    logic [2:0]        bias_sel = '0;
    logic              wave_b = 1'b0;
    logic              invert = 1'b0;
    logic [NP-1:0]     pin_is_com = 4'b0011;
    logic [NP*PW-1:0]  pin_com_sel = {4'd0, 4'd0, 4'd1, 4'd0};
    logic [NP*MC-1:0]  seg_next = '0;
    logic              frame_req;
    logic [NP*3-1:0]   pin_lvl;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    lcd_mux_seq #(.NPINS(NP), .MAX_COM(MC), .DIV_W(DW)) dut (
        .clk(clk), .rst(rst), .en(en), .div_lim(div_lim), .com_num(com_num),
        .bias_sel(bias_sel), .wave_b(wave_b), .invert(invert),
        .pin_is_com(pin_is_com), .pin_com_sel(pin_com_sel),
        .seg_next(seg_next), .frame_req(frame_req), .pin_lvl(pin_lvl)
    );

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [NP*MC-1:0] seg_of(input logic [3:0] s);
        logic [NP*MC-1:0] v = '0;
        v[2*MC+0] = s[0];
        v[2*MC+1] = s[1];
        v[3*MC+0] = s[2];
        v[3*MC+1] = s[3];
        return v;
    endfunction

    // leaves the bench one ns after the edge that enters RUN
    task automatic restart(input vec_t v);
        @(posedge clk); #1;
        en = 1'b0;
        step(1);
        com_num  = v.com_n;
        bias_sel = v.bias;
        wave_b   = v.wb;
        invert   = v.inv;
        seg_next = seg_of(v.seg);
        en       = 1'b1;
        step(2);
    endtask

    initial begin
        step(3);
        check("R1 reset codes", pin_lvl, '0);
        check("R1 reset req", {11'd0, frame_req}, 12'd0);
        rst = 1'b0;
        step(2);
        check("R2 idle ground", pin_lvl, '0);

        // R2: prime cycle
        com_num = 4'd1; bias_sel = 3'd2; seg_next = seg_of(4'b1001);
        en = 1'b1;
        step(1);
        check("R2 prime req", {11'd0, frame_req}, 12'd1);
        check("R2 prime ground", pin_lvl, '0);
        step(1);
        check("R2 run phase0", pin_lvl, {3'd2, 3'd0, 3'd1, 3'd3});

        // table walk
        for (int i = 0; i < 9; i++) begin
            restart(VEC[i]);
            step(VEC[i].ticks * (LIM + 1));
            check($sformatf("R7/R8 vec%0d", i), pin_lvl, VEC[i].exp);
        end

        // R3: phase length
        restart(VEC[0]);
        step(LIM);
        check("R3 phase still 0", pin_lvl, VEC[0].exp);
        step(1);
        check("R3 phase 1 begins", pin_lvl, VEC[1].exp);

        // R11: frame request timing
        restart(VEC[0]);
        check("R11 no req at start", {11'd0, frame_req}, 12'd0);
        step(2 * (LIM + 1) - 2);
        check("R11 no req early", {11'd0, frame_req}, 12'd0);
        step(1);
        check("R11 req last cycle", {11'd0, frame_req}, 12'd1);
        step(1);
        check("R11 req single", {11'd0, frame_req}, 12'd0);

        // R12: double buffering
        restart(VEC[0]);
        seg_next = seg_of(4'b0110);
        step(1);
        check("R12 old data held", pin_lvl, VEC[0].exp);
        step(2 * (LIM + 1) - 1);
        check("R12 new data next frame", pin_lvl, {3'd0, 3'd2, 3'd1, 3'd3});

        // R2: drop enable in run
        en = 1'b0;
        step(1);
        check("R2 disable grounds", pin_lvl, '0);

        // R1: reset during run
        restart(VEC[0]);
        rst = 1'b1;
        step(1);
        check("R1 reset in run", pin_lvl, '0);
        rst = 1'b0;

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule